// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Sequencer

The block turns single-word read requests into read transactions on a serial NOR flash attached over a four-line SPI-style interface. Each request carries an address. The sequencer selects a device and sends an instruction byte. It then sends the flash address and any dummy clocks, collects four bytes of returned data and presents them as one 32-bit word with a one-cycle valid strobe.

A static 32-bit configuration word sets the behaviour:

- bits 7:0 hold the read instruction;
- bits 10:8 hold the dummy byte count;
- bit 27 chooses 3-byte or 4-byte address formation;
- bits 30:28 choose between two stacked devices that share one interface.

The instruction code also decides how many data lines each phase uses. The word resets to 0x000002EB. The word is sampled when a request is accepted and held until chip select is released. The serial clock runs at half the block clock. The serial clock is low while idle. Outputs change when the serial clock falls, and the flash samples them when it rises. Input data is captured on the block-clock edge that ends each high half of the serial clock.

Top module: `flash_read_seq`

## Requirements
- R1: After reset and whenever no transaction is active, both chip selects are high (1), sck_o is 0, io_oe_o is 0, rsp_valid_o is 0 and req_ready_o is 1.
- R2: A request is accepted on a clock edge where req_valid_i and req_ready_o are both high. From the next cycle, the selected chip select is low. sck_o then alternates, starting low, one half-period per clock cycle. The first 8 serial clocks carry the instruction byte (cfg bits 7:0), MSB first, on io_o[0], with io_oe_o = 4'b0001.
- R3: With cfg bit 27 = 0, the address phase sends req_addr_i[23:0], MSB first.
- R4: With cfg bit 27 = 1, the address phase sends {5'b0, req_addr_i[26:0]}, MSB first, as 32 bits.
- R5: The dummy phase follows the address phase. It lasts (cfg bits 10:8) × 8 bit times at the address-phase lane width, with io_oe_o = 0. For instructions 0x03 and 0x13 it is skipped whatever the field holds. The total serial clock count is therefore 8 + address clocks + dummy clocks + data clocks.
- R6: Lane widths depend on the instruction.
  - 0xBB and 0xBC use 2 lines for address, dummy and data.
  - 0xEB and 0xEC use 4 lines for all three.
  - 0x3B and 0x3C use 2 lines for data only.
  - 0x6B and 0x6C use 4 lines for data only.
  - All other codes use 1 line.
  - With 2 lines, io[1] carries the more significant bit; with 4 lines, io[3] does. Outputs drive io_oe_o = 4'b0011 or 4'b1111 during the address phase.
  - Single-line read data arrives on io_i[1].
- R7: The four data bytes are returned little-endian: the first byte received goes to rsp_data_o[7:0] and the fourth to rsp_data_o[31:24]. rsp_valid_o is high for exactly one cycle, the first cycle in which chip select is high again.
- R8: cs1_no is used only when cfg bit 30 = 1, bit 29 = 0 and bit 28 = 1. Every other combination uses cs0_no. The two chip selects are never low together.
- R9: After a transaction, both chip selects stay high for at least 2 clock cycles (one serial clock period) before the next transaction starts.
- R10: The configuration is sampled at acceptance. Changing cfg_i during a transaction does not alter that transaction.
- R11: Configuration bits 25, 24 and 23:16 are ignored: no mode byte and no extra clocks are ever sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 32 | Static read configuration word |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Sequencer idle, can accept a request |
| req_addr_i | input | 32 | Read request address |
| rsp_valid_o | output | 1 | One-cycle strobe, read word available |
| rsp_data_o | output | 32 | Read word, little-endian from the flash bytes |
| sck_o | output | 1 | Serial clock to the flash |
| cs0_no | output | 1 | Chip select, lower device, active low |
| cs1_no | output | 1 | Chip select, upper device, active low |
| io_o | output | 4 | Serial data lines, output value |
| io_oe_o | output | 4 | Serial data lines, output enable per line |
| io_i | input | 4 | Serial data lines, input value |

## Verification
The chip-select assertions compare the active select against the live cfg_i device-select bits. They therefore assume bits 30:28 stay steady while a transaction runs. The bench changes only instruction, dummy and address-width bits in its mid-transaction configuration test. The bench's flash model drives io_i only after a falling serial clock edge, so input data is settled well before the capturing edge. Requests are raised only while req_ready_o is high.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned CNT_W    = 6;
  localparam int unsigned CMD_BITS = 8;
  localparam int unsigned A_NARROW = 24;
  localparam int unsigned A_KEEP   = 27;
  localparam int unsigned A_WIDE   = 32;

  localparam int unsigned B_ADDR4  = 27;
  localparam int unsigned B_PAGE   = 28;
  localparam int unsigned B_SEPBUS = 29;
  localparam int unsigned B_STACK  = 30;

  typedef enum logic [1:0] {LN1 = 2'd0, LN2 = 2'd1, LN4 = 2'd2} lanes_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_GAP
  } state_e;

  typedef struct packed {
    logic [7:0] cmd;
    lanes_e     addr_ln;
    lanes_e     data_ln;
    logic [2:0] dummy;
    logic       addr4;
    logic       use_cs1;
  } seq_cfg_t;

  function automatic seq_cfg_t decode_cfg(input logic [WORD_W-1:0] w);
    seq_cfg_t c;
    c.cmd     = w[7:0];
    c.addr4   = w[B_ADDR4];
    c.use_cs1 = w[B_STACK] & ~w[B_SEPBUS] & w[B_PAGE];
    case (w[7:0])
      8'hBB, 8'hBC: begin c.addr_ln = LN2; c.data_ln = LN2; end
      8'hEB, 8'hEC: begin c.addr_ln = LN4; c.data_ln = LN4; end
      8'h3B, 8'h3C: begin c.addr_ln = LN1; c.data_ln = LN2; end
      8'h6B, 8'h6C: begin c.addr_ln = LN1; c.data_ln = LN4; end
      default:      begin c.addr_ln = LN1; c.data_ln = LN1; end
    endcase
    // plain read codes take no dummy clocks
    c.dummy = (w[7:0] == 8'h03 || w[7:0] == 8'h13) ? 3'd0 : w[10:8];
    return c;
  endfunction
endpackage

// File: rtl/fseq_cfg_latch.sv
module fseq_cfg_latch
  import flash_seq_pkg::*;
#(
  parameter logic [WORD_W-1:0] CFG_RST = 32'h0000_02EB
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  seq_cfg_t cfg_i,
  output seq_cfg_t cfg_o
);
  localparam seq_cfg_t RST_DEC = decode_cfg(CFG_RST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_o <= RST_DEC;
    else if (load_i) cfg_o <= cfg_i;
  end
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int unsigned GAP_CYC = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_valid_i,
  input  seq_cfg_t cfg_i,
  output state_e   state_o,
  output logic     ready_o,
  output logic     accept_o,
  output logic     active_o,
  output logic     ph_o,
  output logic     tick_o,
  output logic     last_o
);
  state_e           state_q;
  logic             ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [6:0]       abits, a_clks, d_clks, r_clks;

  always_comb begin
    abits  = cfg_i.addr4 ? 7'(A_WIDE) : 7'(A_NARROW);
    a_clks = abits >> cfg_i.addr_ln;
    d_clks = {1'b0, cfg_i.dummy, 3'b000} >> cfg_i.addr_ln;
    r_clks = 7'(WORD_W) >> cfg_i.data_ln;
  end

  assign state_o  = state_q;
  assign ph_o     = ph_q;
  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = ready_o & req_valid_i;
  assign active_o = (state_q == ST_CMD) || (state_q == ST_ADDR) ||
                    (state_q == ST_DUMMY) || (state_q == ST_DATA);
  assign tick_o   = active_o & ph_q;
  assign last_o   = tick_o & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= 1'b0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          state_q <= ST_CMD;
          ph_q    <= 1'b0;
          cnt_q   <= CNT_W'(CMD_BITS - 1);
        end
        ST_GAP: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: begin
          ph_q <= ~ph_q;
          if (ph_q) begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            else begin
              case (state_q)
                ST_CMD: begin
                  state_q <= ST_ADDR;
                  cnt_q   <= CNT_W'(a_clks - 7'd1);
                end
                ST_ADDR: begin
                  if (cfg_i.dummy != 3'd0) begin
                    state_q <= ST_DUMMY;
                    cnt_q   <= CNT_W'(d_clks - 7'd1);
                  end else begin
                    state_q <= ST_DATA;
                    cnt_q   <= CNT_W'(r_clks - 7'd1);
                  end
                end
                ST_DUMMY: begin
                  state_q <= ST_DATA;
                  cnt_q   <= CNT_W'(r_clks - 7'd1);
                end
                default: begin
                  state_q <= ST_GAP;
                  cnt_q   <= CNT_W'(GAP_CYC - 1);
                end
              endcase
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/fseq_txrx.sv
module fseq_txrx
  import flash_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [7:0]        cmd_i,
  input  logic              addr4_i,
  input  logic [WORD_W-1:0] req_addr_i,
  input  state_e            state_i,
  input  logic              tick_i,
  input  logic              last_i,
  input  lanes_e            addr_ln_i,
  input  lanes_e            data_ln_i,
  input  logic [3:0]        io_i,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_data_o
);
  localparam int unsigned NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] tx_q, addr_q, rx_q, rx_nxt, rx_swap;
  lanes_e            tx_ln;
  logic              in_cmd, in_addr, ld_addr, cap, done;

  assign in_cmd  = (state_i == ST_CMD);
  assign in_addr = (state_i == ST_ADDR);
  assign ld_addr = last_i & in_cmd;
  assign cap     = tick_i & (state_i == ST_DATA);
  assign done    = last_i & (state_i == ST_DATA);
  assign tx_ln   = in_cmd ? LN1 : addr_ln_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      addr_q <= '0;
    end else if (accept_i) begin
      tx_q   <= {cmd_i, {(WORD_W-8){1'b0}}};
      addr_q <= addr4_i ? {{(A_WIDE-A_KEEP){1'b0}}, req_addr_i[A_KEEP-1:0]}
                        : {req_addr_i[A_NARROW-1:0], {(WORD_W-A_NARROW){1'b0}}};
    end else if (ld_addr) begin
      tx_q <= addr_q;
    end else if (tick_i && (in_cmd || in_addr)) begin
      case (tx_ln)
        LN2:     tx_q <= tx_q << 2;
        LN4:     tx_q <= tx_q << 4;
        default: tx_q <= tx_q << 1;
      endcase
    end
  end

  always_comb begin
    io_o    = 4'b0000;
    io_oe_o = 4'b0000;
    case (tx_ln)
      LN2:     io_o = {2'b00, tx_q[WORD_W-1 -: 2]};
      LN4:     io_o = tx_q[WORD_W-1 -: 4];
      default: io_o = {3'b000, tx_q[WORD_W-1]};
    endcase
    if (in_cmd) io_oe_o = 4'b0001;
    else if (in_addr) begin
      case (addr_ln_i)
        LN2:     io_oe_o = 4'b0011;
        LN4:     io_oe_o = 4'b1111;
        default: io_oe_o = 4'b0001;
      endcase
    end
  end

  always_comb begin
    case (data_ln_i)
      LN2:     rx_nxt = {rx_q[WORD_W-3:0], io_i[1:0]};
      LN4:     rx_nxt = {rx_q[WORD_W-5:0], io_i};
      default: rx_nxt = {rx_q[WORD_W-2:0], io_i[1]};
    endcase
  end

  // first byte on the wire lands in the lowest byte
  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign rx_swap[8*b +: 8] = rx_nxt[8*(NBYTES-1-b) +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q        <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      if (cap)  rx_q       <= rx_nxt;
      if (done) rsp_data_o <= rx_swap;
      rsp_valid_o <= done;
    end
  end
endmodule

// File: rtl/flash_read_seq.sv
module flash_read_seq
  import flash_seq_pkg::*;
#(
  parameter logic [31:0] CFG_RST = 32'h0000_02EB,
  parameter int unsigned GAP_CYC = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] cfg_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] req_addr_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_data_o,
  output logic        sck_o,
  output logic        cs0_no,
  output logic        cs1_no,
  output logic [3:0]  io_o,
  output logic [3:0]  io_oe_o,
  input  logic [3:0]  io_i
);
  seq_cfg_t cfg_now, cfg_q;
  state_e   state;
  logic     accept, active, ph, tick, last;

  assign cfg_now = decode_cfg(cfg_i);

  fseq_cfg_latch #(.CFG_RST(CFG_RST)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .cfg_i  (cfg_now),
    .cfg_o  (cfg_q)
  );

  fseq_ctrl #(.GAP_CYC(GAP_CYC)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .cfg_i       (cfg_q),
    .state_o     (state),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .active_o    (active),
    .ph_o        (ph),
    .tick_o      (tick),
    .last_o      (last)
  );

  fseq_txrx u_txrx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .cmd_i       (cfg_now.cmd),
    .addr4_i     (cfg_now.addr4),
    .req_addr_i  (req_addr_i),
    .state_i     (state),
    .tick_i      (tick),
    .last_i      (last),
    .addr_ln_i   (cfg_q.addr_ln),
    .data_ln_i   (cfg_q.data_ln),
    .io_i        (io_i),
    .io_o        (io_o),
    .io_oe_o     (io_oe_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o)
  );

  assign sck_o  = active & ph;
  assign cs0_no = ~(active & ~cfg_q.use_cs1);
  assign cs1_no = ~(active &  cfg_q.use_cs1);
endmodule

// File: rtl/flash_read_seq_chk.sv
module flash_read_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] cfg_i,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic [31:0] req_addr_i,
  input logic        rsp_valid_o,
  input logic [31:0] rsp_data_o,
  input logic        sck_o,
  input logic        cs0_no,
  input logic        cs1_no,
  input logic [3:0]  io_o,
  input logic [3:0]  io_oe_o,
  input logic [3:0]  io_i
);
  logic idle;
  assign idle = cs0_no & cs1_no;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |-> (!sck_o && io_oe_o == 4'b0000)); // R1
  AST_SCK_ALTERNATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && !$past(idle)) |-> (sck_o != $past(sck_o))); // R2
  AST_CS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!cs0_no && !cs1_no)); // R8
  AST_CS1_STACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs1_no |-> (cfg_i[30] && !cfg_i[29] && cfg_i[28])); // R8
  AST_CS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle) |=> idle); // R9
  AST_READY_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> idle); // R9
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R7
  AST_RSP_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $rose(idle)); // R7
endmodule

bind flash_read_seq flash_read_seq_chk u_chk (.*);

// File: tb/flash_read_seq_bench.sv
`timescale 1ns/1ps
module flash_read_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg = 32'h0000_02EB;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        sck, cs0_n, cs1_n;
  logic [3:0]  io_out, io_oe;
  logic [3:0]  io_in = '0;

  int n_chk = 0, n_err = 0;
  int sck_edges = 0;
  int hi_run = 0, min_gap = 1000;
  bit seen_tx = 0;

  always #4 clk = ~clk;

  flash_read_seq u_flash_read_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_addr_i(req_addr), .rsp_valid_o(rsp_valid),
    .rsp_data_o(rsp_data), .sck_o(sck), .cs0_no(cs0_n), .cs1_no(cs1_n),
    .io_o(io_out), .io_oe_o(io_oe), .io_i(io_in)
  );

  always @(posedge sck) sck_edges++;

  always @(posedge clk) begin
    if (cs0_n && cs1_n) hi_run++;
    else if (hi_run != 0) begin
      if (seen_tx && hi_run < min_gap) min_gap = hi_run;
      seen_tx = 1;
      hi_run  = 0;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // expectations taken from the requirement text
  function automatic int lanes_addr(input logic [7:0] c);
    if (c == 8'hBB || c == 8'hBC) return 2;
    if (c == 8'hEB || c == 8'hEC) return 4;
    return 1;
  endfunction
  function automatic int lanes_data(input logic [7:0] c);
    if (c == 8'hBB || c == 8'hBC || c == 8'h3B || c == 8'h3C) return 2;
    if (c == 8'hEB || c == 8'hEC || c == 8'h6B || c == 8'h6C) return 4;
    return 1;
  endfunction

  task automatic run_read(input logic [31:0] c, input logic [31:0] a,
                          input logic [31:0] stream, input bit mid,
                          input logic [31:0] mid_cfg);
    int aw = lanes_addr(c[7:0]);
    int dw = lanes_data(c[7:0]);
    int dbytes = (c[7:0] == 8'h03 || c[7:0] == 8'h13) ? 0 : int'(c[10:8]);
    int aclk = (c[27] ? 32 : 24) / aw;
    int dclk = dbytes * 8 / aw;
    int nd   = 32 / dw;
    logic [31:0] exp_a = c[27] ? {5'b0, a[26:0]} : {8'b0, a[23:0]};
    logic [31:0] exp_oe = (aw == 4) ? 32'hF : (aw == 2) ? 32'h3 : 32'h1;
    logic [31:0] exp_d = {stream[7:0], stream[15:8], stream[23:16], stream[31:24]};
    logic [7:0]  cmd_got = '0;
    logic [31:0] acc = '0;
    logic [31:0] oe_first = '0;
    logic [31:0] st = stream;
    bit dummy_drive = 0;
    bit got_rsp = 0;
    string atag = c[27] ? "R4" : "R3";
    cfg = c;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    sck_edges = 0;
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    #1 req_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(posedge sck);
      cmd_got = {cmd_got[6:0], io_out[0]};
      if (i == 0) begin
        chk("R8", "cs0_no", {31'b0, cs0_n}, {31'b0, c[30] & ~c[29] & c[28]});
        chk("R8", "cs1_no", {31'b0, cs1_n}, {31'b0, ~(c[30] & ~c[29] & c[28])});
        chk("R2", "cmd oe", {28'b0, io_oe}, 32'h1);
        if (mid) cfg = mid_cfg;
      end
    end
    chk("R2", "instruction", {24'b0, cmd_got}, {24'b0, c[7:0]});
    for (int i = 0; i < aclk; i++) begin
      @(posedge sck);
      if (i == 0) oe_first = {28'b0, io_oe};
      case (aw)
        4:       acc = (acc << 4) | {28'b0, io_out};
        2:       acc = (acc << 2) | {30'b0, io_out[1:0]};
        default: acc = (acc << 1) | {31'b0, io_out[0]};
      endcase
    end
    chk(atag, "address", acc, exp_a);
    chk("R6", "address oe", oe_first, exp_oe);
    for (int i = 0; i < dclk; i++) begin
      @(posedge sck);
      if (io_oe != 4'b0000) dummy_drive = 1;
    end
    chk("R5", "dummy oe", {31'b0, dummy_drive}, 32'h0);
    for (int i = 0; i < nd; i++) begin
      @(negedge sck);
      #1;
      io_in = '0;
      case (dw)
        4:       io_in = st[31:28];
        2:       io_in[1:0] = st[31:30];
        default: io_in[1] = st[31];
      endcase
      st = st << dw;
    end
    for (int i = 0; i < 20 && !got_rsp; i++) begin
      @(negedge clk);
      if (rsp_valid) got_rsp = 1;
    end
    chk("R7", "rsp_valid seen", {31'b0, got_rsp}, 32'h1);
    chk("R7", "cs released at rsp", {31'b0, cs0_n & cs1_n}, 32'h1);
    chk("R7", "data word", rsp_data, exp_d);
    @(negedge clk);
    chk("R7", "rsp one cycle", {31'b0, rsp_valid}, 32'h0);
    chk("R5", "sck count", sck_edges, 8 + aclk + dclk + nd);
  endtask

  task automatic test_reset();
    chk("R1", "cs0_no", {31'b0, cs0_n}, 32'h1);
    chk("R1", "cs1_no", {31'b0, cs1_n}, 32'h1);
    chk("R1", "sck", {31'b0, sck}, 32'h0);
    chk("R1", "oe", {28'b0, io_oe}, 32'h0);
    chk("R1", "ready", {31'b0, req_ready}, 32'h1);
    chk("R1", "rsp_valid", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic test_addr_modes();
    run_read(32'h0000_02EB, 32'h1234_5678, 32'hA1B2_C3D4, 0, 0);  // R3 quad io
    run_read(32'h0800_010B, 32'hFFFF_FFFF, 32'h0F1E_2D3C, 0, 0);  // R4
    run_read(32'h0800_02EC, 32'h0ABC_DEF1, 32'h5566_7788, 0, 0);  // R4 quad io
  endtask

  task automatic test_dummy();
    run_read(32'h0000_0203, 32'h00C3_E10F, 32'h8899_AABB, 0, 0);  // R5 skipped
    run_read(32'h0800_0513, 32'h0123_4567, 32'h1357_9BDF, 0, 0);  // R5 skipped
    run_read(32'h0000_070B, 32'h0000_0001, 32'hFEDC_BA98, 0, 0);  // R5 max
  endtask

  task automatic test_lanes();
    run_read(32'h0800_013C, 32'h0ABC_DEF1, 32'h2468_ACE0, 0, 0);  // R6 dual out
    run_read(32'h0000_026B, 32'h0055_AA55, 32'hC0FF_EE11, 0, 0);  // R6 quad out
    run_read(32'h0000_03BB, 32'h00A5_5A3C, 32'h9669_6996, 0, 0);  // R6 dual io
  endtask

  task automatic test_cs_select();
    run_read(32'h5000_02EB, 32'h0011_2233, 32'h4455_6677, 0, 0);  // R8 upper
    run_read(32'h4000_02EB, 32'h0011_2233, 32'h1122_3344, 0, 0);  // R8 lower
    run_read(32'h7000_02EB, 32'h0011_2233, 32'hDEAD_BEEF, 0, 0);  // R8 sep
  endtask

  task automatic test_mode_bits();
    run_read(32'h03FF_010B, 32'h0076_5432, 32'h0BAD_F00D, 0, 0);  // R11
  endtask

  task automatic test_cfg_hold();
    run_read(32'h0000_02EB, 32'h0034_5678, 32'h3141_5926, 1, 32'h0800_0703); // R10
  endtask

  task automatic test_gap();
    chk("R9", "min cs high cycles", (min_gap >= 2) ? 32'h1 : 32'h0, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_addr_modes();
    test_dummy();
    test_lanes();
    test_cs_select();
    test_mode_bits();
    test_cfg_hold();
    test_gap();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule